// File: doc/BRIEF.md
# Multiprocessor Global Lock Unit with Priority Inheritance

This block arbitrates one global mutual-exclusion lock among several processors that share a heap. Each processor's position on the port vectors is its CPU ID, and a lower ID means a higher priority. A processor asks for the lock by raising its request line and keeping it high. Within one clock the unit either makes it the holder or records it as a waiter and shows a reject status. The holder gives the lock back with a one-cycle release pulse. On the next clock the lock passes straight to the highest-priority processor that is still requesting. The lock is never left free while anyone is waiting.

While a processor holds the lock, the unit keeps an interrupt-inhibit line high toward it. This keeps the critical section from being preempted. To bound how long a high-priority waiter can be blocked, the holder's effective priority is raised to that of the most urgent waiter. It drops back to the holder's own ID once the lock is released. A release pulse from a processor that does not hold the lock changes nothing, and it is reported on an error output.

Top module: `glk_top`

## Requirements
- R1: At most one processor holds the lock at any time: `grant_o` is zero or one-hot.
- R2: If the lock is free and at least one `req_i` bit is sampled high at a clock edge, the lowest requesting ID holds the lock from that edge on. The other requesters are waiting from that same edge.
- R3: A processor that requests while another holds the lock has `reject_o` high from the next edge for as long as it keeps requesting and is not granted. When it lowers its request, `reject_o` is low after the next edge.
- R4: `inhibit_o[k]` is high exactly while processor k holds the lock.
- R5: A release pulse from the holder passes the lock, at the same edge, to the lowest ID that is requesting in that cycle, excluding the holder. If no other processor is requesting, the lock becomes free (`grant_o` all zero).
- R6: The lock is never ownerless while processors wait: `reject_o` nonzero implies `grant_o` nonzero.
- R7: `eff_prio_o[k*W +: W]` (W = bits of a CPU ID) gives processor k's effective priority as an ID value. For the holder it is the minimum of its own ID and the lowest ID with `reject_o` set. For every other processor it is its own ID.
- R8: After the holder releases, its effective priority is back to its own ID from the same edge.
- R9: A release pulse from a processor that is not the holder, or any release while the lock is free, leaves ownership unchanged. It drives `rel_err_o` high for the cycle after that edge.
- R10: The holder's own request line is ignored while it holds the lock: the holder never appears in `reject_o`, and it does not get the lock back through its own release.
- R11: After reset no processor holds or waits, `rel_err_o` is low, and every effective priority equals its own ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NCPU | Level request for the lock, bit k from CPU k |
| rel_i | input | NCPU | One-cycle release pulse, bit k from CPU k |
| grant_o | output | NCPU | Bit k high while CPU k holds the lock |
| reject_o | output | NCPU | Bit k high while CPU k is recorded as waiting |
| inhibit_o | output | NCPU | Interrupt inhibit toward the current holder |
| eff_prio_o | output | NCPU*W | Effective priority of CPU k in field k |
| rel_err_o | output | 1 | Pulse after a release from a non-holder |

## Verification
The bench builds the unit with four processors and two-bit IDs. At that size every combination of request pattern and release pattern is small enough to sweep in full. The sweep runs from each of the sixteen starting ownership situations that a request pattern on a free lock can create. It therefore covers every handover choice and every inheritance case, including a waiter that outranks the holder. A long pseudo-random run then mixes the three kinds of event: withdrawal, stray release and same-cycle release-and-request.

// File: rtl/glk_pkg.sv
package glk_pkg;
  // bits needed to name one processor
  function automatic int unsigned id_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/glk_pick.sv
// Lowest-index selector: lowest ID is the highest priority.
module glk_pick #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] oh_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |vec_i;
  assign oh_o  = vec_i & (~vec_i + N'(1));
endmodule

// File: rtl/glk_ctrl.sv
// Ownership and waiting-set state of the global lock.
module glk_ctrl #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] rel_i,
  output logic         own_vld_o,
  output logic [W-1:0] own_id_o,
  output logic [N-1:0] own_oh_o,
  output logic [N-1:0] wait_o,
  output logic         err_o
);
  logic         own_vld_q, own_vld_d;
  logic [W-1:0] own_id_q,  own_id_d;
  logic [N-1:0] wait_q,    wait_d;
  logic         err_q,     err_d;
  logic [N-1:0] own_oh, cand, pk_oh;
  logic [W-1:0] pk_idx;
  logic         pk_any, hold_rel, st_en;

  assign own_oh = own_vld_q ? (N'(1) << own_id_q) : '0;
  // the holder's own request never competes
  assign cand     = req_i & ~own_oh;
  assign hold_rel = |(rel_i & own_oh);

  glk_pick #(.N(N), .W(W)) cand_pick_i (
    .vec_i (cand),
    .any_o (pk_any),
    .idx_o (pk_idx),
    .oh_o  (pk_oh)
  );

  // next-state process
  always_comb begin
    own_vld_d = own_vld_q;
    own_id_d  = own_id_q;
    wait_d    = cand;
    err_d     = |(rel_i & ~own_oh);
    if (!own_vld_q || hold_rel) begin
      if (pk_any) begin
        own_vld_d = 1'b1;
        own_id_d  = pk_idx;
        wait_d    = cand & ~pk_oh;
      end else begin
        own_vld_d = 1'b0;
        wait_d    = '0;
      end
    end
  end

  // clock enable: only when something can move
  assign st_en = (|req_i) | (|rel_i) | (|wait_q) | err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_id_q  <= '0;
      wait_q    <= '0;
      err_q     <= 1'b0;
    end else if (st_en) begin
      own_vld_q <= own_vld_d;
      own_id_q  <= own_id_d;
      wait_q    <= wait_d;
      err_q     <= err_d;
    end
  end

  assign own_vld_o = own_vld_q;
  assign own_id_o  = own_id_q;
  assign own_oh_o  = own_oh;
  assign wait_o    = wait_q;
  assign err_o     = err_q;

  // R6
  no_orphan_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_vld_q |-> (wait_q == '0));
  // R10
  holder_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q & own_oh) == '0);
  // R2
  free_grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_vld_q && (|req_i)) |=> (own_vld_q &&
      (($past(req_i) & ((N'(1) << own_id_q) - N'(1))) == '0) &&
      (|($past(req_i) & own_oh))));
  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld_q && hold_rel && (|cand)) |=> (own_vld_q && own_id_q != $past(own_id_q)));
  // R9
  stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld_q && !hold_rel && (|rel_i)) |=> (err_q && own_vld_q && $stable(own_id_q)));
endmodule

// File: rtl/glk_boost.sv
// Priority inheritance: the holder takes the most urgent waiter's priority.
module glk_boost #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic           own_vld_i,
  input  logic [W-1:0]   own_id_i,
  input  logic [N-1:0]   wait_i,
  output logic [N*W-1:0] eff_o
);
  logic         w_any;
  logic [W-1:0] w_idx, boosted;
  logic [N-1:0] w_oh;

  glk_pick #(.N(N), .W(W)) wait_pick_i (
    .vec_i (wait_i),
    .any_o (w_any),
    .idx_o (w_idx),
    .oh_o  (w_oh)
  );

  assign boosted = (w_any && (w_idx < own_id_i)) ? w_idx : own_id_i;

  for (genvar k = 0; k < N; k++) begin : g_eff
    assign eff_o[k*W +: W] = (own_vld_i && (own_id_i == W'(k))) ? boosted : W'(k);
    // R7
    always_comb begin
      eff_bound_chk: assert (eff_o[k*W +: W] <= W'(k));
    end
  end
endmodule

// File: rtl/glk_top.sv
module glk_top #(
  parameter int unsigned NCPU = 4,
  localparam int unsigned W   = glk_pkg::id_width(NCPU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   req_i,
  input  logic [NCPU-1:0]   rel_i,
  output logic [NCPU-1:0]   grant_o,
  output logic [NCPU-1:0]   reject_o,
  output logic [NCPU-1:0]   inhibit_o,
  output logic [NCPU*W-1:0] eff_prio_o,
  output logic              rel_err_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            own_vld;
  logic [W-1:0]    own_id;
  logic [NCPU-1:0] own_oh, wait_set;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  glk_ctrl #(.N(NCPU), .W(W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_i     (req_i),
    .rel_i     (rel_i),
    .own_vld_o (own_vld),
    .own_id_o  (own_id),
    .own_oh_o  (own_oh),
    .wait_o    (wait_set),
    .err_o     (rel_err_o)
  );

  glk_boost #(.N(NCPU), .W(W)) boost_i (
    .own_vld_i (own_vld),
    .own_id_i  (own_id),
    .wait_i    (wait_set),
    .eff_o     (eff_prio_o)
  );

  assign grant_o   = own_oh;
  assign inhibit_o = own_oh;
  assign reject_o  = wait_set;

  // R1
  one_holder_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant_o));
  // R6
  wait_has_holder_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|reject_o) |-> (|grant_o));
  // R3
  withdraw_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (own_vld && !(|(rel_i & own_oh)) && (req_i == '0)) |=> (reject_o == '0));
endmodule

// File: tb/glk_top_tb_top.sv
module glk_top_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned W = 2;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]   req, rel;
  logic [N-1:0]   grant, reject, inhibit;
  logic [N*W-1:0] eff;
  logic           rel_err;

  int checks = 0;
  int fails  = 0;

  // bench model state
  bit           m_vld;
  int           m_own;
  bit [N-1:0]   m_wait;
  bit           m_err;

  always #(TCLK/2) clk = ~clk;

  glk_top #(.NCPU(N)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_i (req), .rel_i (rel),
    .grant_o (grant), .reject_o (reject), .inhibit_o (inhibit),
    .eff_prio_o (eff), .rel_err_o (rel_err)
  );

  function automatic int lowest(input bit [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    bit [N-1:0] hm;
    hm = m_vld ? (N'(1) << m_own) : '0;
    chk("R1 grant", grant, hm);
    chk("R3 reject", reject, m_wait);
    chk("R4 inhibit", inhibit, hm);
    chk("R6 waiting implies holder", (reject != 0) && (grant == 0), 0);
    chk("R9 release error", rel_err, m_err);
    for (int k = 0; k < N; k++) begin
      int e;
      e = k;
      if (m_vld && k == m_own && m_wait != 0 && lowest(m_wait) < m_own) e = lowest(m_wait);
      chk("R7 effective priority", eff[k*W +: W], e);
    end
  endtask

  // drive for one edge, update model, sample at the following falling edge
  task automatic step(input bit [N-1:0] r, input bit [N-1:0] l);
    bit [N-1:0] hm, cand;
    bit hrel;
    req = r; rel = l;
    @(posedge clk);
    hm   = m_vld ? (N'(1) << m_own) : '0;
    cand = r & ~hm;
    hrel = m_vld && ((l & hm) != 0);
    m_err = (l & ~hm) != 0;
    if (!m_vld || hrel) begin
      if (cand != 0) begin
        m_vld = 1; m_own = lowest(cand); m_wait = cand & ~(N'(1) << m_own);
      end else begin
        m_vld = 0; m_wait = '0;
      end
    end else m_wait = cand;
    @(negedge clk);
    req = '0; rel = '0;
    check_all();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    summary();
    $finish;
  end

  initial begin
    bit [15:0] lf;
    req = '0; rel = '0; rst_n = 1'b0;
    m_vld = 0; m_own = 0; m_wait = '0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 grant after reset", grant, 0);
    chk("R11 reject after reset", reject, 0);
    chk("R11 error after reset", rel_err, 0);
    for (int k = 0; k < N; k++) chk("R11 eff after reset", eff[k*W +: W], k);

    // R2 simultaneous requests on a free lock
    step(4'b1010, 4'b0000);
    chk("R2 lowest wins", grant, 4'b0010);
    chk("R2 others waiting", reject, 4'b1000);
    // R10 holder request ignored, holder not in waiting set
    step(4'b1010, 4'b0000);
    chk("R10 holder not waiting", reject[1], 0);
    // R7/R8: CPU0 waits on holder 1, holder inherits priority 0
    step(4'b1001, 4'b0000);
    chk("R7 holder boosted", eff[1*W +: W], 0);
    // R5 release: CPU0 takes over; R8 CPU1 back to own ID
    step(4'b1001, 4'b0010);
    chk("R5 handover to lowest", grant, 4'b0001);
    chk("R8 priority restored", eff[1*W +: W], 1);
    // R9 stray release ignored
    step(4'b0000, 4'b0100);
    chk("R9 owner kept", grant, 4'b0001);
    chk("R9 error raised", rel_err, 1);
    // R5 release with nobody else requesting frees the lock
    step(4'b0001, 4'b0001);
    chk("R5 lock freed", grant, 0);
    step(4'b0000, 4'b0000);

    // exhaustive sweep: starting pattern, request pattern, release pattern
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int l = 0; l < 16; l++) begin
          step(N'(s), 4'b0000);
          step(N'(r), N'(l));
          step(4'b0000, 4'b1111);
        end

    // pseudo-random run
    lf = 16'hace1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], (lf[9:8] == 2'b00) ? lf[7:4] : 4'b0000);
    end

    summary();
    $finish;
  end
endmodule